// File: doc/BRIEF.md
# Sample FIFO With Watermark

This block buffers three-axis motion samples between a sensor front end and a reader. Each sample is 48 bits wide and arrives with a one-cycle valid strobe at the output data rate. The buffer holds up to 32 samples, and a reader removes the oldest one with a pop request. A 2-bit mode input selects one of three behaviours. In off mode nothing is stored. In ring mode a sample that arrives while the buffer is full replaces the oldest entry. In halt mode a sample that arrives while the buffer is full is discarded.

The block reports its fill level and a watermark flag, which compares the fill level against a programmable 6-bit mark. It also reports a sticky overflow flag and an event flag, which is set whenever either of those two flags is set. An age counter gives the number of data-rate ticks since the event flag rose. The fill level and the two flags are also packed into a single status byte for a register front end.

Top module: `sample_fifo_wm`

## Requirements
- R1: After reset, fill_level is 0 and pop_avail, wmark_flag, ovf_flag and event_flag are all 0. event_age and status_byte are also 0.
- R2: When cfg_mode is 2'b00 (off) or 2'b11 (reserved, treated as off), samples are not stored and fill_level stays 0.
- R3: In cfg_mode 2'b01 (ring) and 2'b10 (halt), pops return samples oldest first, and pop_data shows the oldest sample while pop_avail is 1. A pop on an empty buffer is ignored. A sample and a pop in the same cycle leave fill_level unchanged.
- R4: In ring mode, a sample that arrives at fill level 32 with no pop in the same cycle discards the oldest entry. fill_level stays 32 and ovf_flag sets.
- R5: In halt mode, a sample that arrives at fill level 32 with no pop in the same cycle is dropped. The stored contents are unchanged and ovf_flag sets.
- R6: ovf_flag stays set until the next completed pop or mode change. A sample and a pop in the same cycle at level 32 does not set it.
- R7: wmark_flag is 1 exactly when cfg_wmark is nonzero and fill_level >= cfg_wmark. A mark of 0 never sets the flag.
- R8: status_byte holds fill_level in bits 5..0, wmark_flag in bit 6 and ovf_flag in bit 7.
- R9: event_flag is the OR of wmark_flag and ovf_flag.
- R10: While event_flag is 1, event_age counts smp_valid strobes that arrive after the cycle in which the flag rose, and it saturates at 31. It is 0 whenever event_flag is 0.
- R11: A change of cfg_mode flushes the buffer. In the next cycle fill_level is 0 and ovf_flag is 0. Samples and pops in the change cycle are ignored, and pop_avail is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00 off, 01 ring, 10 halt, 11 off |
| cfg_wmark | input | 6 | Watermark level, 0 disables the flag |
| smp_valid | input | 1 | Sample strobe, one data-rate tick |
| smp_data | input | 48 | Three-axis sample |
| pop_i | input | 1 | Remove the oldest sample |
| pop_data | output | 48 | Oldest stored sample |
| pop_avail | output | 1 | pop_data is valid and a pop will be taken |
| fill_level | output | 6 | Number of stored samples, 0 to 32 |
| wmark_flag | output | 1 | Fill level has reached the mark |
| ovf_flag | output | 1 | A sample arrived while full |
| event_flag | output | 1 | Watermark or overflow |
| event_age | output | 5 | Ticks since event_flag rose |
| status_byte | output | 8 | {ovf_flag, wmark_flag, fill_level} |

## Verification
Two things can meet in one cycle: a sample arrival and a pop while the buffer is full. That pairing must neither set overflow nor evict an entry. A mode change can also coincide with a sample and a pop, and both must then be dropped by the flush. The bench provokes each pairing on purpose. A scoreboard queue holds the expected samples, so the order of the returned data shows whether an entry was lost or duplicated, and the per-cycle fill level and flag checks show whether overflow was raised wrongly.

// File: rtl/sff_pkg.sv
package sff_pkg;

  typedef enum logic [1:0] {
    SFF_OFF  = 2'b00,
    SFF_RING = 2'b01,
    SFF_HALT = 2'b10,
    SFF_RSVD = 2'b11
  } sff_mode_e;

  // mark of zero disables the comparison
  function automatic logic level_reached(input int unsigned lvl, input int unsigned mark);
    return (mark != 0) && (lvl >= mark);
  endfunction

  // saturating tick counter step
  function automatic int unsigned age_step(input int unsigned cur, input int unsigned lim,
                                           input logic tick);
    if (tick && cur < lim) return cur + 1;
    return cur;
  endfunction

  function automatic logic mode_stores(input sff_mode_e m);
    return (m == SFF_RING) || (m == SFF_HALT);
  endfunction

endpackage

// File: rtl/sff_store.sv
module sff_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 48,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ring_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              rd_done,
  output logic              ovf_hit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  level_q;
  logic              wr_norm, evict;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level_q == '0);
  assign full    = (level_q == FULL_LVL);
  assign rd_done = rd_en && !empty && !flush;
  assign wr_norm = wr_en && !flush && (!full || rd_done);
  assign ovf_hit = wr_en && !flush && full && !rd_done;
  assign evict   = ovf_hit && ring_sel;

  always_ff @(posedge clk) begin
    if (wr_norm || evict) mem[tail_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      level_q <= '0;
    end else if (flush) begin
      head_q  <= '0;
      tail_q  <= '0;
      level_q <= '0;
    end else begin
      if (wr_norm || evict) tail_q <= ptr_inc(tail_q);
      if (rd_done || evict) head_q <= ptr_inc(head_q);
      if (wr_norm && !rd_done)      level_q <= level_q + 1'b1;
      else if (!wr_norm && rd_done) level_q <= level_q - 1'b1;
    end
  end

  assign rd_data = mem[head_q];
  assign level   = level_q;
endmodule

// File: rtl/sff_flags.sv
module sff_flags
  import sff_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int AGE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             tick,
  input  logic             ovf_hit,
  input  logic             rd_done,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] mark,
  output logic             wm_flag,
  output logic             ovf_flag,
  output logic             ev_flag,
  output logic [AGE_W-1:0] ev_age
);
  localparam int unsigned AGE_MAX = (1 << AGE_W) - 1;

  logic             ovf_q;
  logic [AGE_W-1:0] age_q;

  assign wm_flag = level_reached(int'(level), int'(mark));
  assign ev_flag = wm_flag || ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (flush)    ovf_q <= 1'b0;
    else if (ovf_hit)  ovf_q <= 1'b1;
    else if (rd_done)  ovf_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                age_q <= '0;
    else if (flush || !ev_flag) age_q <= '0;
    else                       age_q <= AGE_W'(age_step(int'(age_q), AGE_MAX, tick));
  end

  assign ovf_flag = ovf_q;
  assign ev_age   = ev_flag ? age_q : '0;
endmodule

// File: rtl/sample_fifo_wm.sv
module sample_fifo_wm
  import sff_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 48,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int AGE_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic [CNT_W-1:0]   cfg_wmark,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  smp_data,
  input  logic               pop_i,
  output logic [DATA_W-1:0]  pop_data,
  output logic               pop_avail,
  output logic [CNT_W-1:0]   fill_level,
  output logic               wmark_flag,
  output logic               ovf_flag,
  output logic               event_flag,
  output logic [AGE_W-1:0]   event_age,
  output logic [CNT_W+1:0]   status_byte
);
  sff_mode_e        mode_q;
  logic             flush_now, mode_on, ring_sel;
  logic             store_empty, store_full, rd_done, ovf_hit;
  logic [CNT_W-1:0] level_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SFF_OFF;
    else        mode_q <= sff_mode_e'(cfg_mode);
  end

  assign flush_now = (cfg_mode != mode_q);
  assign mode_on   = mode_stores(mode_q);
  assign ring_sel  = (mode_q == SFF_RING);

  sff_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_now),
    .ring_sel(ring_sel),
    .wr_en   (smp_valid && mode_on),
    .wr_data (smp_data),
    .rd_en   (pop_i && mode_on),
    .rd_data (pop_data),
    .level   (level_w),
    .empty   (store_empty),
    .full    (store_full),
    .rd_done (rd_done),
    .ovf_hit (ovf_hit)
  );

  sff_flags #(.CNT_W(CNT_W), .AGE_W(AGE_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_now),
    .tick    (smp_valid),
    .ovf_hit (ovf_hit),
    .rd_done (rd_done),
    .level   (level_w),
    .mark    (cfg_wmark),
    .wm_flag (wmark_flag),
    .ovf_flag(ovf_flag),
    .ev_flag (event_flag),
    .ev_age  (event_age)
  );

  assign pop_avail   = !store_empty && !flush_now;
  assign fill_level  = level_w;
  assign status_byte = {ovf_flag, wmark_flag, level_w};
endmodule

// File: rtl/sff_checker.sv
module sff_checker #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 48,
  parameter int CNT_W  = 6,
  parameter int AGE_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_now,
  input logic              ovf_hit,
  input logic              ring_sel,
  input logic              mode_on,
  input logic [CNT_W-1:0]  level_w,
  input logic              ovf_flag,
  input logic              event_flag,
  input logic [AGE_W-1:0]  event_age,
  input logic [DATA_W-1:0] pop_data
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_w <= FULL_LVL); // R3

  AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |-> level_w == '0); // R2

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (level_w == '0) && !ovf_flag); // R11

  AST_RING_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && ring_sel) |=> level_w == FULL_LVL); // R4

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !ring_sel) |=> (level_w == FULL_LVL) && $stable(pop_data)); // R5

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> ovf_flag); // R6

  AST_AGE_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(event_flag) |-> event_age == '0); // R10
endmodule

bind sample_fifo_wm sff_checker #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .AGE_W(AGE_W)
) u_sff_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_now (flush_now),
  .ovf_hit   (ovf_hit),
  .ring_sel  (ring_sel),
  .mode_on   (mode_on),
  .level_w   (level_w),
  .ovf_flag  (ovf_flag),
  .event_flag(event_flag),
  .event_age (event_age),
  .pop_data  (pop_data)
);

// File: tb/test_sample_fifo_wm.sv
`timescale 1ns/1ps
module test_sample_fifo_wm;
  localparam int DEPTH = 32;
  localparam int DW    = 48;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [1:0]    cfg_mode = 2'b00;
  logic [5:0]    cfg_wmark = 6'd0;
  logic          smp_valid = 0;
  logic [DW-1:0] smp_data = '0;
  logic          pop_i = 0;
  logic [DW-1:0] pop_data;
  logic          pop_avail, wmark_flag, ovf_flag, event_flag;
  logic [5:0]    fill_level;
  logic [4:0]    event_age;
  logic [7:0]    status_byte;

  always #2 clk = ~clk;

  sample_fifo_wm i_sample_fifo_wm (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wmark(cfg_wmark),
    .smp_valid(smp_valid), .smp_data(smp_data), .pop_i(pop_i),
    .pop_data(pop_data), .pop_avail(pop_avail), .fill_level(fill_level),
    .wmark_flag(wmark_flag), .ovf_flag(ovf_flag), .event_flag(event_flag),
    .event_age(event_age), .status_byte(status_byte)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];
  logic [1:0] m_mode = 2'b00;
  logic m_ovf = 0;
  int m_age = 0;
  logic mon_exp = 0;
  int seq = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic m_wm(input int lvl, input int mk);
    return (mk != 0) && (lvl >= mk);
  endfunction

  // monitor: compares popped data against the scoreboard
  always @(posedge clk) begin
    if (mon_exp) begin
      chk(pop_avail === 1'b1, "R3 pop_avail", 64'(pop_avail), 64'd1);
      chk(pop_data === exp_q[0], "R3 pop order", 64'(pop_data), 64'(exp_q[0]));
      void'(exp_q.pop_front());
    end
  end

  // driver: one clock with model update and full output comparison
  task automatic cyc(input logic v, input logic p, input logic [1:0] md, input logic [5:0] wm);
    logic ev_now, ev_nxt, flush, act, do_pop, full;
    logic [DW-1:0] d;
    int after;
    @(negedge clk);
    seq++;
    d = {16'(seq), 16'(seq * 7), 16'(seq ^ 16'h5a5a)};
    cfg_mode = md; cfg_wmark = wm; smp_valid = v; smp_data = d; pop_i = p;
    ev_now = m_wm(exp_q.size(), int'(wm)) || m_ovf;
    flush = (md != m_mode);
    do_pop = 0;
    if (flush) begin
      exp_q.delete(); m_ovf = 0; m_mode = md; m_age = 0;
    end else begin
      act = (m_mode == 2'b01) || (m_mode == 2'b10);
      do_pop = act && p && (exp_q.size() > 0);
      full = (exp_q.size() == DEPTH);
      if (act && v) begin
        if (!full || do_pop) exp_q.push_back(d);
        else begin
          m_ovf = 1;
          if (m_mode == 2'b01) begin void'(exp_q.pop_front()); exp_q.push_back(d); end
        end
      end
      if (do_pop) m_ovf = 0;
      if (!ev_now) m_age = 0;
      else if (v && m_age < 31) m_age++;
    end
    mon_exp = do_pop;
    after = exp_q.size() - (do_pop ? 1 : 0);
    @(posedge clk); #1;
    mon_exp = 0;
    ev_nxt = m_wm(after, int'(wm)) || m_ovf;
    chk(fill_level == 6'(after), "R3 fill_level", 64'(fill_level), 64'(after));
    chk(wmark_flag == m_wm(after, int'(wm)), "R7 wmark_flag", 64'(wmark_flag), 64'(m_wm(after, int'(wm))));
    chk(ovf_flag == m_ovf, "R6 ovf_flag", 64'(ovf_flag), 64'(m_ovf));
    chk(event_flag == ev_nxt, "R9 event_flag", 64'(event_flag), 64'(ev_nxt));
    chk(event_age == (ev_nxt ? 5'(m_age) : 5'd0), "R10 event_age", 64'(event_age),
        64'(ev_nxt ? m_age : 0));
    chk(status_byte == {m_ovf, m_wm(after, int'(wm)), 6'(after)}, "R8 status_byte",
        64'(status_byte), 64'({m_ovf, m_wm(after, int'(wm)), 6'(after)}));
  endtask

  logic [1:0] md_c = 2'b00;
  logic [5:0] wm_c = 6'd0;
  task automatic push(input int n); for (int i = 0; i < n; i++) cyc(1, 0, md_c, wm_c); endtask
  task automatic pop(input int n);  for (int i = 0; i < n; i++) cyc(0, 1, md_c, wm_c); endtask
  task automatic both(input int n); for (int i = 0; i < n; i++) cyc(1, 1, md_c, wm_c); endtask
  task automatic setm(input logic [1:0] m); md_c = m; cyc(1, 1, md_c, wm_c); endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(fill_level == 0 && !pop_avail, "R1 reset level", 64'(fill_level), 64'd0);
    chk(status_byte == 0 && !event_flag && event_age == 0, "R1 reset flags",
        64'(status_byte), 64'd0);
    @(negedge clk); rst_n = 1;

    // off mode and reserved code store nothing
    wm_c = 6'd1;
    push(3);
    chk(fill_level == 0, "R2 off ignores samples", 64'(fill_level), 64'd0);
    setm(2'b11);
    push(3);
    chk(fill_level == 0 && !wmark_flag, "R2 reserved ignores samples", 64'(fill_level), 64'd0);

    // ring mode basic ordering, empty pop, push+pop
    wm_c = 6'd4;
    setm(2'b01);
    chk(fill_level == 0, "R11 flush on mode change", 64'(fill_level), 64'd0);
    pop(2);
    push(5);
    both(3);
    pop(2);
    chk(fill_level == 3 && !wmark_flag, "R7 below mark", 64'(fill_level), 64'd3);
    push(1);
    chk(wmark_flag, "R7 at mark", 64'(wmark_flag), 64'd1);

    // ring overflow and age saturation
    push(DEPTH - 4);
    both(2);
    chk(!ovf_flag && fill_level == 32, "R6 push+pop at full no overflow", 64'(ovf_flag), 64'd0);
    push(3);
    chk(ovf_flag && fill_level == 32, "R4 ring overflow keeps level", 64'(fill_level), 64'd32);
    push(40);
    chk(event_age == 5'd31, "R10 age saturates", 64'(event_age), 64'd31);
    pop(1);
    chk(!ovf_flag, "R6 cleared by pop", 64'(ovf_flag), 64'd0);
    pop(DEPTH - 1);
    chk(!event_flag && event_age == 0, "R10 age clears with event", 64'(event_age), 64'd0);

    // halt mode overflow
    wm_c = 6'd0;
    setm(2'b10);
    push(DEPTH);
    push(4);
    chk(ovf_flag && fill_level == 32 && !wmark_flag, "R5 halt drop, mark 0 off",
        64'(fill_level), 64'd32);
    chk(pop_data[47:32] == 16'(seq - 35), "R5 oldest kept", 64'(pop_data[47:32]), 64'(seq - 35));
    pop(DEPTH + 1);

    // flush with data present
    wm_c = 6'd2;
    push(6);
    setm(2'b01);
    chk(fill_level == 0 && !ovf_flag && !wmark_flag, "R11 flush drops data",
        64'(fill_level), 64'd0);
    push(2);
    pop(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule